// File: doc/BRIEF.md
# Triggered Channel List Sequencer

This block sits between a hardware trigger source and a single-shot analog converter. Each accepted trigger makes it walk a programmed list of channel numbers from the first entry to the last. For every entry it issues exactly one conversion request and waits for the converter's done strobe. The returned sample is then written, together with the channel number it came from, into a result FIFO. A consumer drains that FIFO through a show-ahead read port.

Two notifications come out of the block. A one-cycle pulse marks each accepted trigger. A level interrupt is raised while the FIFO fill count is strictly greater than a programmed watermark. Because the comparison is strict, a list of N entries needs a watermark of N−1 to interrupt once per list.

A trigger that arrives while a list is still running is recorded as an overrun and otherwise ignored. A result that arrives while the FIFO is full is dropped, and a sticky overflow flag is set. A programmed length above the list depth is clamped to the depth.

Top module: `trig_list_seq`

## Requirements
- R1: After a synchronous active-low reset, the following are all low or zero: conv_req, trig_note, rd_valid, fifo_level, wm_irq, ovr_flag and ovf_flag.
- R2: When the block is idle, a high trig_in with a nonzero lst_len is accepted. In the next cycle, trig_note is high for exactly one cycle and conv_req is high.
- R3: An accepted trigger with length L issues exactly L requests. Each request holds conv_ch at the programmed list entries 0, 1, …, L−1 in that order, and stays stable until conv_done. After the last done, conv_req falls.
- R4: Each conv_done pushes the pair {current channel, conv_data} into the FIFO. rd_valid, rd_ch and rd_data show the oldest pair. A rd_en pulse removes that pair, and fifo_level tracks the number of stored pairs.
- R5: wm_irq is high exactly while fifo_level > wm_level. With a 3-entry list and wm_level 3, it rises only after the fourth result. With wm_level 2, it rises after the third result.
- R6: A trig_in that arrives during a running list produces no trig_note and does not restart or lengthen the list. It sets ovr_flag, which stays set until reset.
- R7: A result that arrives while the FIFO holds FIFO_DEPTH pairs and no read occurs in the same cycle is discarded. fifo_level stays at FIFO_DEPTH, and ovf_flag is set and stays set until reset.
- R8: A trig_in with lst_len equal to 0 is ignored: it produces no trig_note and no conversion request.
- R9: rd_en on an empty FIFO has no effect: fifo_level stays 0 and later results are read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Hardware trigger, one event per high cycle |
| lst_wr_en | input | 1 | Write strobe for one list entry |
| lst_wr_idx | input | IDX_W | List entry index to write |
| lst_wr_ch | input | CH_W | Channel number written to the entry |
| lst_len | input | LEN_W | Number of list entries to visit, captured at trigger acceptance |
| wm_level | input | CNT_W | Watermark; the interrupt fires when the fill level is above it |
| conv_req | output | 1 | Conversion request, held until conv_done |
| conv_ch | output | CH_W | Channel to convert |
| conv_done | input | 1 | Converter finished; conv_data is valid |
| conv_data | input | DATA_W | Conversion result |
| rd_en | input | 1 | Pop the oldest FIFO pair |
| rd_valid | output | 1 | FIFO not empty |
| rd_ch | output | CH_W | Channel of the oldest pair |
| rd_data | output | DATA_W | Result of the oldest pair |
| fifo_level | output | CNT_W | Number of stored pairs |
| trig_note | output | 1 | One-cycle pulse per accepted trigger |
| wm_irq | output | 1 | Watermark interrupt |
| ovr_flag | output | 1 | Sticky trigger-overrun flag |
| ovf_flag | output | 1 | Sticky FIFO-overflow flag |

## Verification
The sequencer is tried with the following patterns:
- Lists of one, three and eight entries, which separate correct pointer stepping and termination from off-by-one list lengths.
- A converter model with random latency, which shows whether the request is held and re-aimed only on done.
- Watermarks set equal to and one below the fill level, which tell a strict comparison from a non-strict one.
- A second trigger during a run, which separates overrun handling from restarting the list.
- Fills past the FIFO depth, which distinguish dropping a result from overwriting a stored one.
- Zero lengths and reads of an empty FIFO, which check that both are ignored.

Random lists and random drain counts, with fixed seeding, then mix all of these cases together.

// File: rtl/seq_pkg.sv
// Shared types for the triggered channel list sequencer.
package seq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/seq_list_regs.sv
// Channel list storage.
// Holds DEPTH channel numbers, written one entry per cycle and read
// combinationally by index. Assumes the write index is below DEPTH.
module seq_list_regs #(
    parameter int CH_W  = 6,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CH_W-1:0]  rd_ch
);
    logic [CH_W-1:0] entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Capture the channel number when this entry is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                entry_q[g] <= wr_ch;
        end
    end

    // Select the entry addressed by the sequencer pointer.
    always_comb rd_ch = entry_q[rd_idx];
endmodule

// File: rtl/seq_ctrl.sv
// List walk controller.
// Accepts a trigger when idle and captures the clamped length. It then
// holds a request per entry until the converter reports done, and
// returns to idle after the last entry with the pointer back at 0.
// Triggers seen while busy set a sticky overrun flag. Assumes conv_done
// is only asserted while conv_req is high.
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic             conv_done,
    output logic             conv_req,
    output logic [IDX_W-1:0] ptr,
    output logic             push,
    output logic             trig_note,
    output logic             ovr_flag
);
    seq_state_e       state_q;
    logic [IDX_W-1:0] ptr_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_eff;
    logic             last;
    logic             note_q;
    logic             ovr_q;

    // Clamp the requested length to the list depth.
    always_comb len_eff = (len_in > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : len_in;

    // Flag the final entry of the captured list.
    always_comb last = (LEN_W'(ptr_q) == (len_q - LEN_W'(1)));

    // Sequence state, pointer, notification pulse and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            len_q   <= '0;
            note_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            note_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (trig_in && (len_eff != '0)) begin
                        state_q <= ST_REQ;
                        ptr_q   <= '0;
                        len_q   <= len_eff;
                        note_q  <= 1'b1;
                    end
                end
                ST_REQ: begin
                    if (trig_in)
                        ovr_q <= 1'b1;
                    if (conv_done) begin
                        if (last) begin
                            ptr_q   <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            ptr_q <= ptr_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the handshake and status outputs.
    always_comb begin
        conv_req  = (state_q == ST_REQ);
        push      = (state_q == ST_REQ) && conv_done;
        ptr       = ptr_q;
        trig_note = note_q;
        ovr_flag  = ovr_q;
    end
endmodule

// File: rtl/seq_fifo.sv
// Result FIFO with watermark compare.
// Stores {channel, data} pairs with a show-ahead read port. A push while
// full without a same-cycle pop is dropped and sets a sticky overflow
// flag. Pops on an empty FIFO are ignored. The interrupt is high while the
// count is strictly above the watermark.
module seq_fifo #(
    parameter int CH_W   = 6,
    parameter int DATA_W = 14,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int ENT_W = CH_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CH_W-1:0]   push_ch,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic [CNT_W-1:0]  wm_level,
    output logic              rd_valid,
    output logic [CH_W-1:0]   rd_ch,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  level,
    output logic              wm_irq,
    output logic              ovf_flag
);
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             do_pop, do_push, full;

    // Decide which transfers take place this cycle.
    always_comb begin
        full    = (cnt_q == CNT_W'(DEPTH));
        do_pop  = pop && (cnt_q != '0);
        do_push = push && (!full || do_pop);
    end

    // Write the incoming pair into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push)
            mem_q[wr_q] <= {push_ch, push_data};
    end

    // Pointers, fill count and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (do_push)
                wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
            if (do_pop)
                rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
            if (push && !do_push)
                ovf_q <= 1'b1;
        end
    end

    // Show-ahead read port and watermark compare.
    always_comb begin
        rd_valid = (cnt_q != '0);
        {rd_ch, rd_data} = mem_q[rd_q];
        level    = cnt_q;
        wm_irq   = (cnt_q > wm_level);
        ovf_flag = ovf_q;
    end
endmodule

// File: rtl/trig_list_seq.sv
// Triggered channel list sequencer, top level.
// Ties the list storage, the walk controller and the result FIFO together.
// Assumes a one-shot converter that answers each request with exactly one
// done strobe.
module trig_list_seq #(
    parameter int CH_W       = 6,
    parameter int DATA_W     = 14,
    parameter int LIST_DEPTH = 8,
    parameter int FIFO_DEPTH = 8,
    localparam int IDX_W = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1,
    localparam int LEN_W = $clog2(LIST_DEPTH + 1),
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              lst_wr_en,
    input  logic [IDX_W-1:0]  lst_wr_idx,
    input  logic [CH_W-1:0]   lst_wr_ch,
    input  logic [LEN_W-1:0]  lst_len,
    input  logic [CNT_W-1:0]  wm_level,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [CH_W-1:0]   rd_ch,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fifo_level,
    output logic              trig_note,
    output logic              wm_irq,
    output logic              ovr_flag,
    output logic              ovf_flag
);
    logic [IDX_W-1:0] walk_ptr;
    logic             push;

    seq_list_regs #(.CH_W(CH_W), .DEPTH(LIST_DEPTH)) u_list (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (lst_wr_en),
        .wr_idx (lst_wr_idx),
        .wr_ch  (lst_wr_ch),
        .rd_idx (walk_ptr),
        .rd_ch  (conv_ch)
    );

    seq_ctrl #(.DEPTH(LIST_DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .len_in    (lst_len),
        .conv_done (conv_done),
        .conv_req  (conv_req),
        .ptr       (walk_ptr),
        .push      (push),
        .trig_note (trig_note),
        .ovr_flag  (ovr_flag)
    );

    seq_fifo #(.CH_W(CH_W), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_ch   (conv_ch),
        .push_data (conv_data),
        .pop       (rd_en),
        .wm_level  (wm_level),
        .rd_valid  (rd_valid),
        .rd_ch     (rd_ch),
        .rd_data   (rd_data),
        .level     (fifo_level),
        .wm_irq    (wm_irq),
        .ovf_flag  (ovf_flag)
    );
endmodule

// File: rtl/trig_list_seq_chk.sv
// Property checker for the triggered channel list sequencer, bound to the top.
module trig_list_seq_chk #(
    parameter int CH_W  = 6,
    parameter int CNT_W = 4,
    parameter int FIFO_DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_in,
    input logic             conv_req,
    input logic [CH_W-1:0]  conv_ch,
    input logic             conv_done,
    input logic             rd_valid,
    input logic [CNT_W-1:0] fifo_level,
    input logic [CNT_W-1:0] wm_level,
    input logic             trig_note,
    input logic             wm_irq,
    input logic             ovr_flag,
    input logic             ovf_flag
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!conv_req && !trig_note && fifo_level == '0 && !ovr_flag && !ovf_flag));

    p_note_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_note |=> !trig_note);

    p_note_starts_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_note |-> conv_req);

    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done) |=> (conv_req && $stable(conv_ch)));

    p_level_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level <= $past(fifo_level) + CNT_W'(1)) && (fifo_level + CNT_W'(1) >= $past(fifo_level)));

    p_wm_equal_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == wm_level) |-> !wm_irq);

    p_no_note_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && trig_in) |=> !trig_note);

    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> ovr_flag);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= CNT_W'(FIFO_DEPTH));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    p_empty_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0) |-> !rd_valid);
endmodule

bind trig_list_seq trig_list_seq_chk #(
    .CH_W(CH_W), .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .conv_req(conv_req),
    .conv_ch(conv_ch), .conv_done(conv_done), .rd_valid(rd_valid),
    .fifo_level(fifo_level), .wm_level(wm_level), .trig_note(trig_note),
    .wm_irq(wm_irq), .ovr_flag(ovr_flag), .ovf_flag(ovf_flag)
);

// File: tb/trig_list_seq_bench.sv
module trig_list_seq_bench;
    localparam int CH_W = 6, DATA_W = 14, LD = 8, FD = 8;
    localparam int IDX_W = 3, LEN_W = 4, CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_in = 1'b0;
    logic lst_wr_en = 1'b0;
    logic [IDX_W-1:0] lst_wr_idx = '0;
    logic [CH_W-1:0] lst_wr_ch = '0;
    logic [LEN_W-1:0] lst_len = '0;
    logic [CNT_W-1:0] wm_level = '0;
    logic conv_req;
    logic [CH_W-1:0] conv_ch;
    logic conv_done = 1'b0;
    logic [DATA_W-1:0] conv_data = '0;
    logic rd_en = 1'b0;
    logic rd_valid;
    logic [CH_W-1:0] rd_ch;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0] fifo_level;
    logic trig_note, wm_irq, ovr_flag, ovf_flag;

    always #2.5 clk = ~clk;

    trig_list_seq #(.CH_W(CH_W), .DATA_W(DATA_W), .LIST_DEPTH(LD), .FIFO_DEPTH(FD)) u_trig_list_seq (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .lst_wr_en(lst_wr_en),
        .lst_wr_idx(lst_wr_idx), .lst_wr_ch(lst_wr_ch), .lst_len(lst_len),
        .wm_level(wm_level), .conv_req(conv_req), .conv_ch(conv_ch),
        .conv_done(conv_done), .conv_data(conv_data), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_ch(rd_ch), .rd_data(rd_data),
        .fifo_level(fifo_level), .trig_note(trig_note), .wm_irq(wm_irq),
        .ovr_flag(ovr_flag), .ovf_flag(ovf_flag)
    );

    int pass_cnt = 0, fail_cnt = 0;
    int exp_list [LD];
    int exp_len = 0, exp_idx = 0, done_cnt = 0, serial = 0;
    bit exp_ovf = 1'b0;
    bit [CH_W+DATA_W-1:0] mq [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int result_of(input int ch, input int n);
        return (ch * 37 + n * 11 + 5) % (1 << DATA_W);
    endfunction

    function automatic bit wm_expect(input int lvl, input int wm);
        return lvl > wm;
    endfunction

    // Converter model: random latency, one done per request; R3 order check.
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (conv_done) conv_done = 1'b0;
            else if (rst_n && conv_req) begin
                if (dly == 0) begin
                    chk(exp_idx < exp_len, "R3 request count", exp_idx, exp_len);
                    if (exp_idx < exp_len)
                        chk(conv_ch == exp_list[exp_idx], "R3 channel order", conv_ch, exp_list[exp_idx]);
                    conv_data = DATA_W'(result_of(conv_ch, serial));
                    if (mq.size() < FD) mq.push_back({conv_ch, conv_data});
                    else exp_ovf = 1'b1;
                    conv_done = 1'b1;
                    serial++; exp_idx++; done_cnt++;
                    dly = $urandom_range(0, 3);
                end else dly--;
            end
        end
    end

    task automatic prog(input int idx, input int ch);
        @(negedge clk);
        lst_wr_en = 1'b1; lst_wr_idx = IDX_W'(idx); lst_wr_ch = CH_W'(ch);
        exp_list[idx] = ch;
        @(negedge clk);
        lst_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 3) begin
            @(negedge clk);
            if (!conv_req && !conv_done) quiet++; else quiet = 0;
        end
    endtask

    // Pulse a trigger while idle, check R2 at the following negedge.
    task automatic fire(input int len);
        exp_len = len; exp_idx = 0; done_cnt = 0;
        @(negedge clk);
        lst_len = LEN_W'(len); trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        chk(trig_note && conv_req, "R2 note and request", {trig_note, conv_req}, 3);
        @(negedge clk);
        chk(!trig_note, "R2 note one cycle", trig_note, 0);
    endtask

    task automatic pop_check();
        @(negedge clk);
        chk(rd_valid == (mq.size() != 0), "R4 valid", rd_valid, mq.size() != 0);
        if (mq.size() != 0)
            chk({rd_ch, rd_data} == mq[0], "R4 head pair", {rd_ch, rd_data}, mq[0]);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (mq.size() != 0) void'(mq.pop_front());
        chk(fifo_level == CNT_W'(mq.size()), "R4 level", fifo_level, mq.size());
    endtask

    task automatic check_wm(input string req);
        @(negedge clk);
        chk(wm_irq == wm_expect(mq.size(), wm_level), req, wm_irq, wm_expect(mq.size(), wm_level));
        chk(fifo_level == CNT_W'(mq.size()), "R4 level after list", fifo_level, mq.size());
        chk(ovf_flag == exp_ovf, "R7 overflow flag", ovf_flag, exp_ovf);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fail_cnt++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({conv_req, trig_note, rd_valid, wm_irq, ovr_flag, ovf_flag} == 6'b0 && fifo_level == 0,
            "R1 reset outputs", {conv_req, trig_note, rd_valid, wm_irq, ovr_flag, ovf_flag}, 0);

        // R9: pop on empty is ignored
        pop_check();
        chk(fifo_level == 0, "R9 empty pop level", fifo_level, 0);

        // Directed: three channels, watermark 3 (strict compare, R5)
        prog(0, 48); prog(1, 54); prog(2, 55);
        wm_level = 4'd3;
        fire(3); wait_idle();
        chk(done_cnt == 3, "R3 three requests", done_cnt, 3);
        check_wm("R5 wm equal stays low");
        chk(!wm_irq, "R5 no irq at level 3 with wm 3", wm_irq, 0);
        fire(1); wait_idle();
        check_wm("R5 wm above");
        chk(wm_irq, "R5 irq after fourth result", wm_irq, 1);
        repeat (4) pop_check();
        chk(fifo_level == 0, "R9 later results intact", fifo_level, 0);
        wm_level = 4'd2;
        fire(3); wait_idle();
        check_wm("R5 wm two");
        chk(wm_irq, "R5 irq after third result with wm 2", wm_irq, 1);
        pop_check();
        chk(!wm_irq, "R5 irq clears at wm", wm_irq, 0);
        repeat (2) pop_check();

        // R8: zero length ignored
        @(negedge clk); lst_len = '0; trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
        chk(!trig_note && !conv_req, "R8 zero length ignored", {trig_note, conv_req}, 0);
        repeat (3) @(negedge clk);
        chk(!conv_req && fifo_level == 0, "R8 no conversion", conv_req, 0);

        // R6: trigger during a running list
        chk(!ovr_flag, "R6 overrun clear before", ovr_flag, 0);
        fire(3);
        trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
        chk(!trig_note, "R6 no note when busy", trig_note, 0);
        chk(ovr_flag, "R6 overrun set", ovr_flag, 1);
        wait_idle();
        chk(done_cnt == 3, "R6 list not restarted", done_cnt, 3);
        chk(ovr_flag, "R6 overrun sticky", ovr_flag, 1);
        repeat (3) pop_check();

        // R7: overfill with an eight-entry list, twice
        for (int i = 0; i < LD; i++) prog(i, 8 + i * 5);
        wm_level = 4'd7;
        fire(8); wait_idle();
        check_wm("R5 full fifo");
        chk(!ovf_flag, "R7 no overflow at depth", ovf_flag, 0);
        fire(2); wait_idle();
        check_wm("R5 after overflow");
        chk(ovf_flag && fifo_level == FD, "R7 dropped and sticky", {ovf_flag, fifo_level}, {1'b1, 4'(FD)});
        repeat (FD) pop_check();

        // Random lists, watermarks and drain counts
        for (int it = 0; it < 30; it++) begin
            int len = $urandom_range(1, LD);
            for (int i = 0; i < len; i++) prog(i, $urandom_range(0, 63));
            wm_level = CNT_W'($urandom_range(0, FD));
            fire(len); wait_idle();
            chk(done_cnt == len, "R3 random request count", done_cnt, len);
            check_wm("R5 random watermark");
            for (int k = $urandom_range(0, mq.size()); k > 0; k--) pop_check();
        end
        while (mq.size() != 0) pop_check();

        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end
endmodule